// File: doc/BRIEF.md
# Bidirectional Parallel Port with Input Pulldowns

This block is a byte-wide general-purpose I/O port on a simple register bus. Software sets each pin's direction, writes output values into a data latch, and reads back a per-bit mix of latch contents and sampled pin levels. For every pin the block drives three signals to an external pad model: the output value, the output-driver enable and the pulldown enable.

The pulldown is controlled by a write-only inhibit register. It acts only on pins configured as inputs. A static configuration input selects the reset state of the inhibit register. With the input high, the port leaves reset with every pin an input and every pulldown switched off. With the input low, every pin leaves reset as an input with its pulldown switched on. Pin levels pass through one sampling register before they can be read.

Top module: `gpioPort`

## Requirements
- R1: After a reset with `cfgPdOff` low, `padOe` is 0x00, `padOut` is 0x00, `padPdEn` is 0xFF, and a read of the direction address (0x04) returns 0x00.
- R2: Direction bit i set to 1 drives `padOe[i]` high and drives the latch bit on `padOut[i]`. Direction bit 0 drops `padOe[i]`.
- R3: A read of address 0x00 returns, for each bit i, the latch bit where direction bit i is 1, and the sampled pin level where it is 0.
- R4: A write to address 0x00 updates all eight latch bits whatever the direction bits are. For an input pin it leaves `padOe` low. The written value appears on `padOut` and in reads once the pin is switched to output.
- R5: The pulldown-inhibit register at address 0x10 is write-only, and every read of 0x10 returns 0x00.
- R6: `padPdEn[i]` is high exactly when direction bit i is 0 and inhibit bit i is 0. Writing 1 to an inhibit bit switches that pulldown off.
- R7: A reset with `cfgPdOff` high loads 0xFF into the inhibit register and 0x00 into the direction register. All pins are then inputs, and `padPdEn` is 0x00.
- R8: The direction register at address 0x04 reads back the last value written to it.
- R9: The level returned for an input bit is the value `padIn` held at the previous rising clock edge, taken through one register stage.
- R10: Reads of any address other than 0x00, 0x04 and 0x10 return 0x00. Writes to such addresses change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPdOff | input | 1 | Static configuration: 1 makes reset disable all pulldowns |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| padIn | input | 8 | Pin levels from the pad model |
| padOut | output | 8 | Output value per pin |
| padOe | output | 8 | Output-driver enable per pin |
| padPdEn | output | 8 | Pulldown enable per pin |

## Verification
Random direction masks are mixed with random latch and pin values. This shows whether each data-read bit takes the latch or the pin depending on its own direction bit, and whether the whole byte follows one source. Directed all-input and all-output masks test the two extremes of the read mix. Random writes to unused addresses show whether any stray write reaches a register. Resets with the configuration input at each level, followed by single-bit inhibit writes, separate the pulldown rule from the direction rule.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrPdInh;
    logic selData;
    logic selDir;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h04,
  parameter logic [ADDR_W-1:0] PDI_ADDR  = 'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobes_t      strobes
);
  logic hitData, hitDir, hitPdi;

  always_comb begin
    hitData = (busAddr == DATA_ADDR);
    hitDir  = (busAddr == DIR_ADDR);
    hitPdi  = (busAddr == PDI_ADDR);
    strobes.wrData  = busWrEn & hitData;
    strobes.wrDir   = busWrEn & hitDir;
    strobes.wrPdInh = busWrEn & hitPdi;
    strobes.selData = hitData;
    strobes.selDir  = hitDir;
  end
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgPdOff,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPdEn
);
  logic [WIDTH-1:0] latchQ, dirQ, pdInhQ, pinQ, mixed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      pdInhQ <= {WIDTH{cfgPdOff}};
      pinQ   <= '0;
    end else begin
      pinQ <= padIn;
      if (strobes.wrData)  latchQ <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
      if (strobes.wrPdInh) pdInhQ <= wrData;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      mixed[i]   = dirQ[i] ? latchQ[i] : pinQ[i];
      padOe[i]   = dirQ[i];
      padOut[i]  = latchQ[i];
      padPdEn[i] = ~dirQ[i] & ~pdInhQ[i];
    end
  end

  always_comb begin
    if (strobes.selData)     rdData = mixed;
    else if (strobes.selDir) rdData = dirQ;
    else                     rdData = '0;
  end
endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h04,
  parameter logic [ADDR_W-1:0] PDI_ADDR  = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPdOff,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPdEn
);
  ctrlStrobes_t strobes;

  gpioCtrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .PDI_ADDR(PDI_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobes(strobes)
  );

  gpioDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgPdOff(cfgPdOff), .strobes(strobes),
    .wrData(busWrData), .padIn(padIn), .rdData(busRdData),
    .padOut(padOut), .padOe(padOe), .padPdEn(padPdEn)
  );
endmodule

// File: rtl/gpioPortChk.sv
module gpioPortChk #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h04,
  parameter logic [ADDR_W-1:0] PDI_ADDR  = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPdEn
);
  logic unusedAddr;
  assign unusedAddr = (busAddr != DATA_ADDR) && (busAddr != DIR_ADDR) && (busAddr != PDI_ADDR);

  // R6
  pd_only_on_inputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPdEn & padOe) == '0);

  // R4
  latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DATA_ADDR) |=> padOut == $past(busWrData));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DIR_ADDR) |=> padOe == $past(busWrData));

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && unusedAddr) |=> ($stable(padOut) && $stable(padOe) && $stable(padPdEn)));

  // R5
  pdi_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == PDI_ADDR) |-> busRdData == '0);

  // R10
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    unusedAddr |-> busRdData == '0);

  // R3
  out_bits_read_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DATA_ADDR) |-> ((busRdData ^ padOut) & padOe) == '0);

  // R8
  dir_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DIR_ADDR) |-> busRdData == padOe);
endmodule

bind gpioPort gpioPortChk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .PDI_ADDR(PDI_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .busRdData(busRdData), .padOut(padOut), .padOe(padOe), .padPdEn(padPdEn)
);

// File: tb/tb_gpioPort.sv
`timescale 1ns/1ps
module tb_gpioPort;
  logic clk = 0, rstN = 0, cfgPdOff = 0, busWrEn = 0;
  logic [7:0] busAddr = 0, busWrData = 0, busRdData, padIn = 0, padOut, padOe, padPdEn;
  int checks = 0, errors = 0;
  logic [7:0] mLatch = 0, mDir = 0, mPdi = 0, mPin = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpioPort dut (.clk(clk), .rstN(rstN), .cfgPdOff(cfgPdOff), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPdEn(padPdEn));

  // R9 reference: pin level seen after one register stage
  always @(posedge clk or negedge rstN)
    if (!rstN) mPin <= 0; else mPin <= padIn;

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a == 8'h00) return (mLatch & mDir) | (mPin & ~mDir);
    if (a == 8'h04) return mDir;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1;
    @(posedge clk); #1;
    if (a == 8'h00) mLatch = d;
    else if (a == 8'h04) mDir = d;
    else if (a == 8'h10) mPdi = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a);
    @(negedge clk); busAddr = a; #1;
    chk(req, busRdData, expRead(a));
  endtask

  task automatic padChk(input string req);
    @(negedge clk); #1;
    chk({req, " padOe"}, padOe, mDir);
    chk({req, " padOut"}, padOut, mLatch);
    chk({req, " padPdEn"}, padPdEn, ~mDir & ~mPdi);
  endtask

  task automatic doReset(input logic cfg);
    @(negedge clk); rstN = 0; cfgPdOff = cfg; busWrEn = 0;
    mLatch = 0; mDir = 0; mPdi = {8{cfg}};
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    doReset(0);
    // R1 reset state
    padChk("R1");
    rdChk("R1", 8'h04);
    // R9 one-stage sampling
    @(negedge clk); padIn = 8'hA5; busAddr = 8'h00; #1;
    chk("R9 before edge", busRdData, 8'h00);
    @(negedge clk); #1;
    chk("R9 after edge", busRdData, 8'hA5);
    // R4 write to input pins: latch updated, pin stays input
    wr(8'h00, 8'h3C);
    padChk("R4");
    rdChk("R4 input read shows pin", 8'h00);
    wr(8'h04, 8'hFF);
    rdChk("R4 latch visible as output", 8'h00);
    padChk("R2 all outputs");
    // R3 mixed directions
    wr(8'h04, 8'h0F); padIn = 8'hF0;
    rdChk("R3 mix", 8'h00);
    rdChk("R8", 8'h04);
    // R5 / R6 pulldown inhibit
    wr(8'h04, 8'h00);
    wr(8'h10, 8'h01);
    padChk("R6 single inhibit");
    rdChk("R5", 8'h10);
    // R10 unused writes/reads
    wr(8'h08, 8'hFF);
    padChk("R10 stray write");
    rdChk("R10 unused read", 8'h08);
    // R7 reset with config high
    doReset(1);
    padChk("R7");
    rdChk("R7 dir", 8'h04);
    wr(8'h10, 8'h00);
    padChk("R6 inhibit cleared");
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a, d;
      case ($urandom % 5)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      padIn = 8'($urandom);
      wr(a, d);
      rdChk("R3 random data read", 8'h00);
      rdChk("R8 random dir read", 8'h04);
      rdChk("R10/R5 random other read", 8'($urandom));
      padChk("R2/R6 random pads");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule